// File: doc/BRIEF.md
# Header-Relative Frame Byte Extractor

This block sits beside a receive path and watches each incoming Ethernet frame one byte at a time. Four independent byte slots each pick one byte out of the frame. A slot finds its byte by counting from one of three reference points: the start of the destination address, the first byte after the layer 2 header, or the first byte after the layer 3 header. The four picked bytes are packed into a 32-bit property word. A downstream receive filer can match on that word, for example to pick out TCP flags or a preamble byte that the filer would not otherwise see.

The header boundaries are supplied by an external parser as one-byte strobes that mark the first byte after each header. Software programs one 32-bit configuration register. Each slot has a 2-bit mode and a 6-bit offset in that register. The block takes a private copy of the register at each start of frame, so a write made during a frame never changes that frame's result. One cycle after the end-of-frame byte, the block presents the word with a one-cycle valid pulse.

The FSM has three states:
- `ST_IDLE` waits for a start of frame.
- `ST_FRAME` collects bytes.
- `ST_EMIT` drives the one-cycle result pulse.

Transitions:
- IDLE→FRAME on a valid start byte. IDLE→EMIT when that byte also ends the frame.
- FRAME→EMIT on a valid end byte. FRAME→FRAME on a fresh start byte, which restarts the frame.
- EMIT→IDLE with no new start. EMIT→FRAME (or EMIT→EMIT for a one-byte frame) when a start byte arrives during the pulse.

Top module: `hdr_byte_extractor`

## Requirements
- R1: After reset the configuration register reads zero, `prop_valid` is low and `cfg_err` is zero.
- R2: The register uses MSB-first numbering. Slot k has its mode at bits [31-8k:30-8k] and its offset at bits [29-8k:24-8k]. Writes are visible on `cfg_rdata` the cycle after `cfg_we`.
- R3: Mode 2'b00 disables a slot, and its byte reads as zero in the word.
- R4: Mode 2'b01 with `fifo_mode` low selects the byte at (offset − 8) from the first destination-address byte. The stream carries 7 preamble bytes and the delimiter first, so the destination address starts at stream index 8. The selected byte is therefore stream index = offset, and offsets 0..7 reach the preamble and delimiter.
- R5: Mode 2'b10 selects the byte that lies offset bytes after the byte marked by `l2_end`. An offset of 0 selects the marked byte.
- R6: Mode 2'b11 selects the byte that lies offset bytes after the byte marked by `l3_end`. An offset of 0 selects the marked byte.
- R7: `prop_word` is {slot0, slot1, slot2, slot3}, with slot 0 in bits [31:24].
- R8: `prop_valid` is high for exactly one cycle: the cycle after the clock edge that takes the frame's `in_eof` byte. `prop_word` holds that frame's result during that cycle.
- R9: A slot reads zero when the frame ends before its target byte arrives, or when its header strobe never occurs. The last byte of the frame is still reachable.
- R10: With `fifo_mode` high the destination address is stream index 0, and mode 01 selects index offset − 8. A mode 01 offset below 8 raises `cfg_err[k]` for that slot, and the slot reads zero.
- R11: A register write takes effect at the next start of frame. A write made during a frame leaves that frame's word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| fifo_mode | input | 1 | High when the stream carries no preamble |
| in_valid | input | 1 | Stream byte valid |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Stream byte |
| l2_end | input | 1 | Marks the first byte after the layer 2 header |
| l3_end | input | 1 | Marks the first byte after the layer 3 header |
| prop_valid | output | 1 | One-cycle result strobe |
| prop_word | output | 32 | Packed property word |
| cfg_err | output | 4 | Per-slot reserved-setting flag |

## Verification
The bench targets the following corner cases, each tied to a likely design error:
- Offsets 0 and 7 in address mode. A design that counts from the destination address without the bias of 8 returns data bytes instead of the preamble and delimiter.
- Offset 0 in a header mode. An off-by-one design picks the byte after the strobe.
- The very last byte of a frame. A design that drops it returns zero.
- A target past the end of the frame, and a strobe that never arrives. A design that keeps stale bytes from the previous frame returns them here.
- A write made during a frame. A design without the start-of-frame copy produces a mixed word.
- FIFO-mode offsets below 8. These show whether the error flag is raised and whether the slot is suppressed.

// File: rtl/hbx_pkg.sv
package hbx_pkg;
    localparam int NSLOT    = 4;
    localparam int BYTE_W   = 8;
    localparam int CTL_W    = 2;
    localparam int OFF_W    = 6;
    localparam int FIELD_W  = CTL_W + OFF_W;
    localparam int CFG_W    = NSLOT * FIELD_W;
    localparam int PRE_LEN  = 8;

    typedef enum logic [CTL_W-1:0] {
        SM_OFF  = 2'b00,
        SM_ADDR = 2'b01,
        SM_L2   = 2'b10,
        SM_L3   = 2'b11
    } slot_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_FRAME = 2'b01,
        ST_EMIT  = 2'b10
    } ext_state_e;
endpackage

// File: rtl/hbx_cfg.sv
module hbx_cfg
    import hbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             load,
    input  logic             fifo_in,
    output logic [CFG_W-1:0] rdata,
    output logic [CFG_W-1:0] cur_cfg,
    output logic             cur_fifo,
    output logic [NSLOT-1:0] err
);
    logic [CFG_W-1:0] reg_q;
    logic [CFG_W-1:0] act_q;
    logic             act_fifo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (we) begin
            reg_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q      <= '0;
            act_fifo_q <= 1'b0;
        end else if (load) begin
            act_q      <= reg_q;
            act_fifo_q <= fifo_in;
        end
    end

    assign rdata    = reg_q;
    assign cur_cfg  = load ? reg_q : act_q;
    assign cur_fifo = load ? fifo_in : act_fifo_q;

    for (genvar k = 0; k < NSLOT; k++) begin : g_err
        localparam int TOP = CFG_W - 1 - k * FIELD_W;
        assign err[k] = fifo_in
                     && (reg_q[TOP -: CTL_W] == SM_ADDR)
                     && (reg_q[TOP-CTL_W -: OFF_W] < OFF_W'(PRE_LEN));
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_q)); // R11
endmodule

// File: rtl/hbx_hdr_track.sv
module hbx_hdr_track #(
    parameter int IDX_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             sof,
    input  logic             strobe,
    input  logic [IDX_W-1:0] pos,
    output logic             seen_now,
    output logic [IDX_W-1:0] base_now
);
    logic             seen_q;
    logic [IDX_W-1:0] base_q;
    logic             prior;

    always_comb begin
        prior    = seen_q && !sof;
        seen_now = prior || (take && strobe);
        base_now = prior ? base_q : pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            base_q <= '0;
        end else if (take) begin
            seen_q <= seen_now;
            base_q <= base_now;
        end
    end
endmodule

// File: rtl/hbx_slot.sv
module hbx_slot
    import hbx_pkg::*;
#(
    parameter int IDX_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              sof,
    input  logic [BYTE_W-1:0] data,
    input  slot_mode_e        mode,
    input  logic [OFF_W-1:0]  off,
    input  logic              fifo,
    input  logic [IDX_W-1:0]  pos,
    input  logic              l2_seen,
    input  logic [IDX_W-1:0]  l2_base,
    input  logic              l3_seen,
    input  logic [IDX_W-1:0]  l3_base,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int TW = IDX_W + 1;
    localparam logic [TW-1:0] BIAS = TW'(PRE_LEN);

    logic [TW-1:0] off_x;
    logic [TW-1:0] tgt;
    logic          ok;
    logic          live;
    logic          hit;
    logic          live_q;

    assign off_x = TW'(off);

    always_comb begin
        tgt  = '0;
        ok   = 1'b0;
        live = 1'b1;
        unique case (mode)
            SM_OFF: begin
                live = 1'b0;
            end
            SM_ADDR: begin
                if (fifo) begin
                    live = (off_x >= BIAS);
                    ok   = live;
                    tgt  = off_x - BIAS;
                end else begin
                    ok  = 1'b1;
                    tgt = off_x;
                end
            end
            SM_L2: begin
                ok  = l2_seen;
                tgt = {1'b0, l2_base} + off_x;
            end
            SM_L3: begin
                ok  = l3_seen;
                tgt = {1'b0, l3_base} + off_x;
            end
        endcase
        hit = take && ok && ({1'b0, pos} == tgt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            live_q <= 1'b0;
        end else if (take && sof) begin
            byte_q <= hit ? data : '0;
            live_q <= live;
        end else if (hit) begin
            byte_q <= data;
        end
    end

    AST_SLOT_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q |-> (byte_q == '0)); // R3
endmodule

// File: rtl/hdr_byte_extractor.sv
module hdr_byte_extractor
    import hbx_pkg::*;
#(
    parameter int IDX_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    input  logic                    fifo_mode,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic                    in_eof,
    input  logic [7:0]              in_data,
    input  logic                    l2_end,
    input  logic                    l3_end,
    output logic                    prop_valid,
    output logic [31:0]             prop_word,
    output logic [3:0]              cfg_err
);
    localparam logic [IDX_W-1:0] POS_MAX = '1;

    ext_state_e       state_q, state_d;
    logic             take;
    logic             start;
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] pos;
    logic [CFG_W-1:0] cur_cfg;
    logic             cur_fifo;
    logic             l2_seen, l3_seen;
    logic [IDX_W-1:0] l2_base, l3_base;
    logic [BYTE_W-1:0] slot_byte [NSLOT];

    assign start = in_valid && in_sof;
    assign take  = in_valid && (in_sof || state_q == ST_FRAME);
    assign pos   = in_sof ? '0 : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= (pos == POS_MAX) ? POS_MAX : pos + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = in_eof ? ST_EMIT : ST_FRAME;
            ST_FRAME: if (take && in_eof) state_d = ST_EMIT;
            ST_EMIT:  begin
                if (start) state_d = in_eof ? ST_EMIT : ST_FRAME;
                else       state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    hbx_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .load     (start),
        .fifo_in  (fifo_mode),
        .rdata    (cfg_rdata),
        .cur_cfg  (cur_cfg),
        .cur_fifo (cur_fifo),
        .err      (cfg_err)
    );

    hbx_hdr_track #(.IDX_W(IDX_W)) u_l2 (
        .clk (clk), .rst_n (rst_n), .take (take), .sof (in_sof),
        .strobe (l2_end), .pos (pos),
        .seen_now (l2_seen), .base_now (l2_base)
    );

    hbx_hdr_track #(.IDX_W(IDX_W)) u_l3 (
        .clk (clk), .rst_n (rst_n), .take (take), .sof (in_sof),
        .strobe (l3_end), .pos (pos),
        .seen_now (l3_seen), .base_now (l3_base)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        localparam int TOP = CFG_W - 1 - k * FIELD_W;
        hbx_slot #(.IDX_W(IDX_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (take),
            .sof     (in_sof),
            .data    (in_data),
            .mode    (slot_mode_e'(cur_cfg[TOP -: CTL_W])),
            .off     (cur_cfg[TOP-CTL_W -: OFF_W]),
            .fifo    (cur_fifo),
            .pos     (pos),
            .l2_seen (l2_seen),
            .l2_base (l2_base),
            .l3_seen (l3_seen),
            .l3_base (l3_base),
            .byte_q  (slot_byte[k])
        );
        assign prop_word[TOP -: BYTE_W] = slot_byte[k];
    end

    always_comb begin
        prop_valid = (state_q == ST_EMIT);
    end

    AST_EOF_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_eof) |=> prop_valid); // R8
    AST_EMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_valid && !(start && in_eof)) |=> !prop_valid); // R8
endmodule

// File: tb/tb_hdr_byte_extractor.sv
module tb_hdr_byte_extractor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        fifo_mode = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        l2_end = 1'b0, l3_end = 1'b0;
    logic        prop_valid;
    logic [31:0] prop_word;
    logic [3:0]  cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] fr [0:127];

    always #4 clk = ~clk;

    hdr_byte_extractor dut (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata), .fifo_mode (fifo_mode), .in_valid (in_valid),
        .in_sof (in_sof), .in_eof (in_eof), .in_data (in_data),
        .l2_end (l2_end), .l3_end (l3_end), .prop_valid (prop_valid),
        .prop_word (prop_word), .cfg_err (cfg_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [31:0] c, input int k, input bit fifo,
                                             input int n, input int l2, input int l3);
        logic [1:0] m;
        int off, idx;
        m   = c[31-8*k -: 2];
        off = int'(c[29-8*k -: 6]);
        idx = -1;
        case (m)
            2'b01: idx = fifo ? off - 8 : off;
            2'b10: idx = (l2 < 0) ? -1 : l2 + off;
            2'b11: idx = (l3 < 0) ? -1 : l3 + off;
            default: idx = -1;
        endcase
        if (idx < 0 || idx >= n) return 8'h00;
        return fr[idx];
    endfunction

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fill(input bit fifo, input int seed);
        for (int i = 0; i < 128; i++) begin
            if (!fifo && i < 7)       fr[i] = 8'h55;
            else if (!fifo && i == 7) fr[i] = 8'hD5;
            else                      fr[i] = 8'((i * 37 + seed) & 8'hFF) | 8'h01;
        end
    endtask

    task automatic send(input int n, input int l2, input int l3,
                        input bit mid_we, input logic [31:0] mid_val);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = fr[i];
            in_sof = (i == 0); in_eof = (i == n - 1);
            l2_end = (i == l2); l3_end = (i == l3);
            cfg_we = mid_we && (i == 3); cfg_wdata = mid_val;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        l2_end = 1'b0; l3_end = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic run(input string req, input logic [31:0] c, input bit fifo,
                       input int n, input int l2, input int l3,
                       input bit mid_we, input logic [31:0] mid_val);
        logic [31:0] exp;
        exp = {exp_byte(c, 0, fifo, n, l2, l3), exp_byte(c, 1, fifo, n, l2, l3),
               exp_byte(c, 2, fifo, n, l2, l3), exp_byte(c, 3, fifo, n, l2, l3)};
        if (fifo && c[31:30] == 2'b01 && c[29:24] < 8) exp[31:24] = 8'h00;
        if (fifo && c[23:22] == 2'b01 && c[21:16] < 8) exp[23:16] = 8'h00;
        if (fifo && c[15:14] == 2'b01 && c[13:8]  < 8) exp[15:8]  = 8'h00;
        if (fifo && c[7:6]   == 2'b01 && c[5:0]   < 8) exp[7:0]   = 8'h00;
        send(n, l2, l3, mid_we, mid_val);
        check({req, " R8 valid pulse"}, 32'(prop_valid), 32'd1);
        check({req, " word"}, prop_word, exp);
        @(negedge clk);
        check({req, " R8 valid drops"}, 32'(prop_valid), 32'd0);
    endtask

    task automatic t_reset;
        check("R1 cfg reset", cfg_rdata, 32'h0);
        check("R1 valid reset", 32'(prop_valid), 32'd0);
        check("R1 err reset", 32'(cfg_err), 32'd0);
    endtask

    task automatic t_layout;
        write_cfg(32'h4800_0000);
        check("R2 readback", cfg_rdata, 32'h4800_0000);
        fill(0, 3);
        run("R2 R7 slot0 MSB", 32'h4800_0000, 0, 20, -1, -1, 0, '0);
    endtask

    task automatic t_addr;
        logic [31:0] c;
        c = {2'b01, 6'd0, 2'b01, 6'd7, 2'b01, 6'd8, 2'b01, 6'd20};
        write_cfg(c);
        fill(0, 11);
        run("R4 R7 address mode", c, 0, 64, 22, 42, 0, '0);
    endtask

    task automatic t_hdr;
        logic [31:0] c;
        c = {2'b10, 6'd0, 2'b10, 6'd5, 2'b11, 6'd0, 2'b11, 6'd9};
        write_cfg(c);
        fill(0, 23);
        run("R5 R6 header modes", c, 0, 70, 22, 42, 0, '0);
        fill(0, 61);
        run("R5 R6 other boundaries", c, 0, 90, 30, 57, 0, '0);
    endtask

    task automatic t_off;
        logic [31:0] c;
        c = {2'b00, 6'd5, 2'b10, 6'd3, 2'b00, 6'd63, 2'b01, 6'd9};
        write_cfg(c);
        fill(0, 5);
        run("R3 disabled slots", c, 0, 50, 14, 34, 0, '0);
    endtask

    task automatic t_short;
        logic [31:0] c;
        c = {2'b10, 6'd10, 2'b01, 6'd30, 2'b11, 6'd0, 2'b01, 6'd15};
        write_cfg(c);
        fill(0, 77);
        run("R9 short frame, missing strobe, last byte", c, 0, 16, 12, -1, 0, '0);
    endtask

    task automatic t_fifo;
        logic [31:0] c;
        c = {2'b01, 6'd8, 2'b01, 6'd3, 2'b01, 6'd63, 2'b10, 6'd2};
        write_cfg(c);
        @(negedge clk);
        fifo_mode = 1'b1;
        @(negedge clk);
        check("R10 cfg_err slot1", 32'(cfg_err), 32'h2);
        fill(1, 41);
        run("R10 fifo mode", c, 1, 60, 14, -1, 0, '0);
        fifo_mode = 1'b0;
        @(negedge clk);
        check("R10 cfg_err clear", 32'(cfg_err), 32'h0);
    endtask

    task automatic t_cfg_timing;
        logic [31:0] a, b;
        a = {2'b01, 6'd8, 2'b01, 6'd9, 2'b01, 6'd10, 2'b01, 6'd11};
        b = {2'b01, 6'd12, 2'b00, 6'd0, 2'b01, 6'd13, 2'b00, 6'd0};
        write_cfg(a);
        fill(0, 90);
        run("R11 mid-frame write ignored", a, 0, 30, -1, -1, 1, b);
        check("R11 write stored", cfg_rdata, b);
        run("R11 new cfg at next frame", b, 0, 30, -1, -1, 0, '0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_addr();
        t_hdr();
        t_off();
        t_short();
        t_fifo();
        t_cfg_timing();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule